// File: doc/BRIEF.md
# DMA Thread Abort and Recovery Controller

This block follows the execution state of one manager thread and `NUM_CH` channel threads of a DMA engine. It handles what happens when a thread aborts. A channel that aborts stops issuing bus accesses and invalidates its cached entries. It then waits until its bus transactions that are still in flight have retired, and only then settles into the fault state. The manager thread has no bus traffic to drain, so it settles into the fault state at once. A shared abort interrupt stays raised for as long as any thread is in a fault state.

Software recovers a faulted thread in two steps. It first writes a kill instruction, together with the thread it targets, into a debug-instruction register. It then writes a debug-command register to execute that instruction. There are two register ports, one secure and one non-secure, and each holds its own debug-instruction register. A command from the non-secure port that targets a secure thread is dropped. The security of a channel comes from a dynamic bit given when the channel is started. The security of the manager, of the event/interrupt resources and of the peripheral request interfaces is sampled from configuration inputs once, when reset is released.

Instruction decoding, the bus master and the cache storage are outside this block. They appear only as simple strobes and inputs.

Top module: `dma_abt_top`

## Requirements
- R1: A channel in Executing that sees its abort input moves to FaultCompleting at the next clock edge. `ch_cache_inv` pulses for exactly that first FaultCompleting cycle. `ch_quiesce` is high for the whole time the channel is in FaultCompleting.
- R2: A channel stays in FaultCompleting while its outstanding-transaction count is nonzero. It moves to Faulting at the first clock edge at which it samples a count of zero.
- R3: The manager in Executing that sees `mgr_abort` moves directly to Faulting (3) at the next edge, with no draining state.
- R4: `irq_abort` is high in every cycle in which any thread is in FaultCompleting or Faulting. It goes low only once every such thread has been killed.
- R5: The fault status shows which threads are faulting. `ch_fault` bit i is high while channel i is in state 2 or 3, and `mgr_fault` is high while the manager is in state 3. The abort cause is latched into `ch_cause` or `mgr_cause` at the abort edge.
- R6: A start command loads the channel program counter with `go_pc`. A precise abort loads it with `ch_abort_pc`. An imprecise abort leaves it unchanged.
- R7: The debug-instruction word is laid out as follows: bits [7:0] hold the opcode (kill = 8'h01), bit [8] is 1 when the target is a channel, and bits [8+CH_W:9] hold the channel index. It is written at address 0. Writing address 1 with bit 0 set executes it. A kill that reaches a thread in Faulting moves it to Stopped (0) at that edge.
- R8: A kill that targets a thread in Stopped, Executing or FaultCompleting is ignored. An executed instruction whose opcode is not the kill opcode is ignored.
- R9: A command from the non-secure port that targets a secure thread (non-secure bit 0) is ignored and leaves the state unchanged. The secure port may kill any thread. The non-secure port may kill non-secure threads.
- R10: `mgr_ns`, `irq_ns` and `periph_ns` take the configuration inputs at the first clock edge after reset release. Later changes on those inputs have no effect.
- R11: `ch_ns_valid` bit i is high exactly while channel i is not Stopped. `ch_ns` reports the non-secure bit given at start, and reads 0 while the channel is Stopped.
- R12: States are encoded as Stopped=0, Executing=1, FaultCompleting=2, Faulting=3. A start (`go_valid`/`mgr_go`) is honoured only in Stopped. An abort is honoured only in Executing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mgr_ns | input | 1 | Manager security, sampled after reset |
| cfg_irq_ns | input | NUM_EV | Event/interrupt security, sampled after reset |
| cfg_periph_ns | input | NUM_PR | Peripheral request security, sampled after reset |
| mgr_go | input | 1 | Start the manager thread |
| mgr_abort | input | 1 | Manager abort indication |
| mgr_abort_cause | input | CAUSE_W | Manager abort cause |
| go_valid | input | 1 | Start a channel |
| go_ch | input | CH_W | Channel to start |
| go_ns | input | 1 | Non-secure bit of the started channel |
| go_pc | input | PC_W | Start address |
| ch_abort | input | NUM_CH | Per-channel abort |
| ch_abort_precise | input | NUM_CH | Per-channel precise flag |
| ch_abort_cause | input | NUM_CH*CAUSE_W | Per-channel abort cause |
| ch_abort_pc | input | NUM_CH*PC_W | Address of the aborting instruction |
| ch_outstanding | input | NUM_CH*OST_W | In-flight bus transactions per channel |
| s_wr | input | 1 | Secure port write strobe |
| s_addr | input | 1 | Secure port address (0 instruction, 1 command) |
| s_wdata | input | DW | Secure port write data |
| ns_wr | input | 1 | Non-secure port write strobe |
| ns_addr | input | 1 | Non-secure port address |
| ns_wdata | input | DW | Non-secure port write data |
| mgr_state | output | 2 | Manager state |
| mgr_fault | output | 1 | Manager faulting |
| mgr_cause | output | CAUSE_W | Manager abort cause |
| mgr_ns | output | 1 | Captured manager security |
| irq_ns | output | NUM_EV | Captured event/interrupt security |
| periph_ns | output | NUM_PR | Captured peripheral security |
| ch_state | output | NUM_CH*2 | Channel states |
| ch_fault | output | NUM_CH | Channel faulting flags |
| ch_cause | output | NUM_CH*CAUSE_W | Channel abort causes |
| ch_pc | output | NUM_CH*PC_W | Channel program counters |
| ch_ns | output | NUM_CH | Channel non-secure bits |
| ch_ns_valid | output | NUM_CH | Non-secure bit valid |
| ch_quiesce | output | NUM_CH | No new bus accesses (draining) |
| ch_cache_inv | output | NUM_CH | Cache invalidate pulse |
| irq_abort | output | 1 | Abort interrupt |

## Verification
Some properties are checked on every cycle. A channel abort always lands in FaultCompleting with the invalidate pulse. The drain holds while transactions remain and exits once none do. An imprecise abort keeps the program counter. The manager faults directly. A non-secure kill of a secure faulting manager changes nothing. Other behaviour can only be shown by the bench's sweep over channels, security, precision and drain depth. That covers the two-write recovery sequence, the interrupt staying up while a second thread still faults, kills sent to threads in the wrong state, the capture of configuration once at reset, and the reported value of the non-secure bit.

// File: rtl/dma_abt_pkg.sv
package dma_abt_pkg;
  typedef enum logic [1:0] {
    TS_STOP  = 2'd0,
    TS_EXEC  = 2'd1,
    TS_FCOMP = 2'd2,
    TS_FAULT = 2'd3
  } thr_state_e;

  localparam logic [7:0] OP_KILL = 8'h01;
endpackage

// File: rtl/dma_abt_rstsync.sv
module dma_abt_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dma_abt_dbgport.sv
module dma_abt_dbgport #(
  parameter int CH_W = 2,
  parameter int DW   = 9 + CH_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            addr,
  input  logic [DW-1:0]   wdata,
  output logic            kill_vld,
  output logic            kill_to_ch,
  output logic [CH_W-1:0] kill_idx
);
  import dma_abt_pkg::*;

  logic [7:0]      op_q;
  logic            to_ch_q;
  logic [CH_W-1:0] idx_q;
  logic            inst_en;

  assign inst_en = wr && !addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= 8'h00;
      to_ch_q <= 1'b0;
      idx_q   <= '0;
    end else if (inst_en) begin
      op_q    <= wdata[7:0];
      to_ch_q <= wdata[8];
      idx_q   <= wdata[8+CH_W:9];
    end
  end

  // the command executes the instruction held before this write
  assign kill_vld   = wr && addr && wdata[0] && (op_q == OP_KILL);
  assign kill_to_ch = to_ch_q;
  assign kill_idx   = idx_q;
endmodule

// File: rtl/dma_abt_mgr.sv
module dma_abt_mgr #(
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic               abort,
  input  logic [CAUSE_W-1:0] abort_cause,
  input  logic               kill,
  output logic [1:0]         state,
  output logic [CAUSE_W-1:0] cause
);
  import dma_abt_pkg::*;

  thr_state_e         st_q, st_d;
  logic [CAUSE_W-1:0] cause_q;
  logic               cause_en;

  assign cause_en = (st_q == TS_EXEC) && abort;

  always_comb begin
    st_d = st_q;
    case (st_q)
      TS_STOP:  if (go)    st_d = TS_EXEC;
      TS_EXEC:  if (abort) st_d = TS_FAULT;
      TS_FCOMP: st_d = TS_FAULT;
      TS_FAULT: if (kill)  st_d = TS_STOP;
      default:  st_d = TS_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TS_STOP;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_en) cause_q <= abort_cause;
  end

  assign state = st_q;
  assign cause = cause_q;

  // R3: manager skips the draining state
  a_r3_mgr_direct_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_EXEC && abort) |=> (st_q == TS_FAULT));

  // R8: kill outside Faulting leaves the manager running
  a_r8_mgr_kill_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_EXEC && kill && !abort) |=> (st_q == TS_EXEC));
endmodule

// File: rtl/dma_abt_chan.sv
module dma_abt_chan #(
  parameter int PC_W    = 16,
  parameter int CAUSE_W = 4,
  parameter int OST_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic               go_ns,
  input  logic [PC_W-1:0]    go_pc,
  input  logic               abort,
  input  logic               abort_precise,
  input  logic [CAUSE_W-1:0] abort_cause,
  input  logic [PC_W-1:0]    abort_pc,
  input  logic [OST_W-1:0]   outstanding,
  input  logic               kill,
  output logic [1:0]         state,
  output logic [CAUSE_W-1:0] cause,
  output logic [PC_W-1:0]    pc,
  output logic               ns,
  output logic               ns_valid,
  output logic               quiesce,
  output logic               cache_inv
);
  import dma_abt_pkg::*;

  thr_state_e         st_q, st_d;
  logic [PC_W-1:0]    pc_q, pc_d;
  logic               pc_en;
  logic [CAUSE_W-1:0] cause_q;
  logic               ns_q;
  logic               inv_q;
  logic               start_ok, abort_ok;

  assign start_ok = (st_q == TS_STOP) && go;
  assign abort_ok = (st_q == TS_EXEC) && abort;

  always_comb begin
    st_d = st_q;
    case (st_q)
      TS_STOP:  if (start_ok)           st_d = TS_EXEC;
      TS_EXEC:  if (abort_ok)           st_d = TS_FCOMP;
      TS_FCOMP: if (outstanding == '0)  st_d = TS_FAULT;
      TS_FAULT: if (kill)               st_d = TS_STOP;
      default:  st_d = TS_STOP;
    endcase
  end

  always_comb begin
    pc_en = 1'b0;
    pc_d  = pc_q;
    if (start_ok) begin
      pc_en = 1'b1;
      pc_d  = go_pc;
    end else if (abort_ok && abort_precise) begin
      pc_en = 1'b1;
      pc_d  = abort_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TS_STOP;
      inv_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      inv_q <= abort_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (abort_ok) cause_q <= abort_cause;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ns_q <= 1'b0;
    else if (start_ok) ns_q <= go_ns;
  end

  assign state     = st_q;
  assign cause     = cause_q;
  assign pc        = pc_q;
  assign ns_valid  = (st_q != TS_STOP);
  assign ns        = ns_q && ns_valid;
  assign quiesce   = (st_q == TS_FCOMP);
  assign cache_inv = inv_q;

  // R1: abort lands in FaultCompleting with the invalidate pulse
  a_r1_enter_fcomp: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ok |=> (st_q == TS_FCOMP && cache_inv));

  // R2: drain holds while transactions remain
  a_r2_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_FCOMP && outstanding != '0) |=> (st_q == TS_FCOMP));

  // R2: drain ends when none remain
  a_r2_drain_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_FCOMP && outstanding == '0) |=> (st_q == TS_FAULT));

  // R6: imprecise abort keeps the program counter
  a_r6_imprecise_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_ok && !abort_precise) |=> $stable(pc_q));

  // R8: kill while draining is ignored
  a_r8_kill_fcomp: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_FCOMP && outstanding != '0 && kill) |=> (st_q == TS_FCOMP));
endmodule

// File: rtl/dma_abt_top.sv
module dma_abt_top #(
  parameter int NUM_CH  = 4,
  parameter int PC_W    = 16,
  parameter int CAUSE_W = 4,
  parameter int OST_W   = 3,
  parameter int NUM_EV  = 4,
  parameter int NUM_PR  = 4,
  parameter int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int DW      = 9 + CH_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_mgr_ns,
  input  logic [NUM_EV-1:0]         cfg_irq_ns,
  input  logic [NUM_PR-1:0]         cfg_periph_ns,
  input  logic                      mgr_go,
  input  logic                      mgr_abort,
  input  logic [CAUSE_W-1:0]        mgr_abort_cause,
  input  logic                      go_valid,
  input  logic [CH_W-1:0]           go_ch,
  input  logic                      go_ns,
  input  logic [PC_W-1:0]           go_pc,
  input  logic [NUM_CH-1:0]         ch_abort,
  input  logic [NUM_CH-1:0]         ch_abort_precise,
  input  logic [NUM_CH*CAUSE_W-1:0] ch_abort_cause,
  input  logic [NUM_CH*PC_W-1:0]    ch_abort_pc,
  input  logic [NUM_CH*OST_W-1:0]   ch_outstanding,
  input  logic                      s_wr,
  input  logic                      s_addr,
  input  logic [DW-1:0]             s_wdata,
  input  logic                      ns_wr,
  input  logic                      ns_addr,
  input  logic [DW-1:0]             ns_wdata,
  output logic [1:0]                mgr_state,
  output logic                      mgr_fault,
  output logic [CAUSE_W-1:0]        mgr_cause,
  output logic                      mgr_ns,
  output logic [NUM_EV-1:0]         irq_ns,
  output logic [NUM_PR-1:0]         periph_ns,
  output logic [NUM_CH*2-1:0]       ch_state,
  output logic [NUM_CH-1:0]         ch_fault,
  output logic [NUM_CH*CAUSE_W-1:0] ch_cause,
  output logic [NUM_CH*PC_W-1:0]    ch_pc,
  output logic [NUM_CH-1:0]         ch_ns,
  output logic [NUM_CH-1:0]         ch_ns_valid,
  output logic [NUM_CH-1:0]         ch_quiesce,
  output logic [NUM_CH-1:0]         ch_cache_inv,
  output logic                      irq_abort
);
  import dma_abt_pkg::*;

  localparam int NPORT = 2;  // index 0 secure, 1 non-secure

  logic rst_n_i;

  dma_abt_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  // configuration capture on first edge after reset release
  logic              cap_done_q;
  logic              mgr_ns_q;
  logic [NUM_EV-1:0] irq_ns_q;
  logic [NUM_PR-1:0] periph_ns_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cap_done_q  <= 1'b0;
      mgr_ns_q    <= 1'b0;
      irq_ns_q    <= '0;
      periph_ns_q <= '0;
    end else if (!cap_done_q) begin
      cap_done_q  <= 1'b1;
      mgr_ns_q    <= cfg_mgr_ns;
      irq_ns_q    <= cfg_irq_ns;
      periph_ns_q <= cfg_periph_ns;
    end
  end

  assign mgr_ns    = mgr_ns_q;
  assign irq_ns    = irq_ns_q;
  assign periph_ns = periph_ns_q;

  // debug register ports
  logic [NPORT-1:0]     p_wr, p_addr, p_kv, p_toch;
  logic [DW-1:0]        p_wdata [NPORT];
  logic [CH_W-1:0]      p_idx   [NPORT];

  assign p_wr[0]    = s_wr;
  assign p_addr[0]  = s_addr;
  assign p_wdata[0] = s_wdata;
  assign p_wr[1]    = ns_wr;
  assign p_addr[1]  = ns_addr;
  assign p_wdata[1] = ns_wdata;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dma_abt_dbgport #(.CH_W(CH_W), .DW(DW)) u_dbg (
      .clk(clk), .rst_n(rst_n_i),
      .wr(p_wr[p]), .addr(p_addr[p]), .wdata(p_wdata[p]),
      .kill_vld(p_kv[p]), .kill_to_ch(p_toch[p]), .kill_idx(p_idx[p])
    );
  end

  // manager thread
  logic mgr_kill_s, mgr_kill_ns, mgr_kill;

  assign mgr_kill_s  = p_kv[0] && !p_toch[0];
  assign mgr_kill_ns = p_kv[1] && !p_toch[1];
  assign mgr_kill    = mgr_kill_s || (mgr_kill_ns && mgr_ns_q);

  dma_abt_mgr #(.CAUSE_W(CAUSE_W)) u_mgr (
    .clk(clk), .rst_n(rst_n_i),
    .go(mgr_go), .abort(mgr_abort), .abort_cause(mgr_abort_cause),
    .kill(mgr_kill), .state(mgr_state), .cause(mgr_cause)
  );

  assign mgr_fault = (mgr_state == TS_FAULT);

  // channel threads
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic ch_go, ch_kill;

    assign ch_go   = go_valid && (go_ch == CH_W'(i));
    assign ch_kill = (p_kv[0] && p_toch[0] && p_idx[0] == CH_W'(i)) ||
                     (p_kv[1] && p_toch[1] && p_idx[1] == CH_W'(i) && ch_ns[i]);

    dma_abt_chan #(.PC_W(PC_W), .CAUSE_W(CAUSE_W), .OST_W(OST_W)) u_ch (
      .clk(clk), .rst_n(rst_n_i),
      .go(ch_go), .go_ns(go_ns), .go_pc(go_pc),
      .abort(ch_abort[i]), .abort_precise(ch_abort_precise[i]),
      .abort_cause(ch_abort_cause[i*CAUSE_W +: CAUSE_W]),
      .abort_pc(ch_abort_pc[i*PC_W +: PC_W]),
      .outstanding(ch_outstanding[i*OST_W +: OST_W]),
      .kill(ch_kill),
      .state(ch_state[i*2 +: 2]),
      .cause(ch_cause[i*CAUSE_W +: CAUSE_W]),
      .pc(ch_pc[i*PC_W +: PC_W]),
      .ns(ch_ns[i]), .ns_valid(ch_ns_valid[i]),
      .quiesce(ch_quiesce[i]), .cache_inv(ch_cache_inv[i])
    );

    assign ch_fault[i] = ch_state[i*2+1];

    // R4: a channel abort raises the interrupt
    a_r4_ch_irq: assert property (@(posedge clk) disable iff (!rst_n_i)
      (ch_state[i*2 +: 2] == TS_EXEC && ch_abort[i]) |=> irq_abort);
  end

  assign irq_abort = mgr_fault || (|ch_fault);

  // R4: a manager abort raises the interrupt
  a_r4_mgr_irq: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mgr_state == TS_EXEC && mgr_abort) |=> irq_abort);

  // R9: non-secure kill of a secure faulting manager has no effect
  a_r9_ns_mgr_blocked: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mgr_state == TS_FAULT && mgr_kill_ns && !mgr_ns_q && !mgr_kill_s)
      |=> (mgr_state == TS_FAULT));
endmodule

// File: tb/dma_abt_top_tb_top.sv
module dma_abt_top_tb_top;
  localparam int NUM_CH = 4, PC_W = 16, CAUSE_W = 4, OST_W = 3;
  localparam int NUM_EV = 4, NUM_PR = 4, CH_W = 2, DW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_mgr_ns = 1'b0;
  logic [NUM_EV-1:0] cfg_irq_ns = '0;
  logic [NUM_PR-1:0] cfg_periph_ns = '0;
  logic mgr_go = 0, mgr_abort = 0;
  logic [CAUSE_W-1:0] mgr_abort_cause = '0;
  logic go_valid = 0, go_ns = 0;
  logic [CH_W-1:0] go_ch = '0;
  logic [PC_W-1:0] go_pc = '0;
  logic [NUM_CH-1:0] ch_abort = '0, ch_abort_precise = '0;
  logic [NUM_CH*CAUSE_W-1:0] ch_abort_cause = '0;
  logic [NUM_CH*PC_W-1:0] ch_abort_pc = '0;
  logic [NUM_CH*OST_W-1:0] ch_outstanding = '0;
  logic s_wr = 0, s_addr = 0, ns_wr = 0, ns_addr = 0;
  logic [DW-1:0] s_wdata = '0, ns_wdata = '0;
  logic [1:0] mgr_state;
  logic mgr_fault, mgr_ns, irq_abort;
  logic [CAUSE_W-1:0] mgr_cause;
  logic [NUM_EV-1:0] irq_ns;
  logic [NUM_PR-1:0] periph_ns;
  logic [NUM_CH*2-1:0] ch_state;
  logic [NUM_CH-1:0] ch_fault, ch_ns, ch_ns_valid, ch_quiesce, ch_cache_inv;
  logic [NUM_CH*CAUSE_W-1:0] ch_cause;
  logic [NUM_CH*PC_W-1:0] ch_pc;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_abt_top dut_i (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic do_reset(input bit mns);
    rst_n = 0; cfg_mgr_ns = mns; cfg_irq_ns = 4'hA; cfg_periph_ns = 4'h5;
    tick(); tick();
    rst_n = 1;
    repeat (4) tick();
  endtask

  task automatic wr_port(input bit sec, input bit a, input logic [DW-1:0] d);
    if (sec) begin s_wr = 1; s_addr = a; s_wdata = d; end
    else     begin ns_wr = 1; ns_addr = a; ns_wdata = d; end
    tick();
    s_wr = 0; ns_wr = 0;
  endtask

  task automatic kill(input bit sec, input bit to_ch, input int idx, input logic [7:0] op);
    wr_port(sec, 1'b0, {CH_W'(idx), to_ch, op});
    wr_port(sec, 1'b1, DW'(1));
  endtask

  task automatic start_ch(input int i, input bit ns, input logic [PC_W-1:0] pc);
    go_valid = 1; go_ch = CH_W'(i); go_ns = ns; go_pc = pc;
    tick();
    go_valid = 0;
  endtask

  task automatic abort_ch(input int i, input bit prec, input logic [CAUSE_W-1:0] c,
                          input logic [PC_W-1:0] apc);
    ch_abort[i] = 1; ch_abort_precise[i] = prec;
    ch_abort_cause[i*CAUSE_W +: CAUSE_W] = c;
    ch_abort_pc[i*PC_W +: PC_W] = apc;
    tick();
    ch_abort[i] = 0;
  endtask

  function automatic logic [1:0] st(input int i);
    return ch_state[i*2 +: 2];
  endfunction

  initial begin
    do_reset(1'b0);
    // reset state
    chk(ch_state == '0 && mgr_state == 0, "R12 reset state", ch_state, 0);
    chk(irq_abort == 0, "R4 reset irq", irq_abort, 0);
    chk(ch_ns_valid == 0 && ch_ns == 0, "R11 reset ns", ch_ns_valid, 0);
    chk(mgr_ns == 0 && irq_ns == 4'hA && periph_ns == 4'h5, "R10 capture",
        {mgr_ns, irq_ns, periph_ns}, {1'b0, 4'hA, 4'h5});
    cfg_mgr_ns = 1; cfg_irq_ns = 4'h3; cfg_periph_ns = 4'hC;
    tick(); tick();
    chk(mgr_ns == 0 && irq_ns == 4'hA && periph_ns == 4'h5, "R10 later cfg ignored",
        {mgr_ns, irq_ns, periph_ns}, {1'b0, 4'hA, 4'h5});

    // sweep: channel x security x precise x drain depth
    for (int i = 0; i < NUM_CH; i++)
      for (int ns = 0; ns < 2; ns++)
        for (int pr = 0; pr < 2; pr++)
          for (int n = 0; n < 3; n++) begin
            logic [PC_W-1:0] gpc, apc, epc;
            logic [CAUSE_W-1:0] cz;
            gpc = PC_W'(16'h1000 + i * 64 + ns * 16 + pr * 4 + n);
            apc = PC_W'(16'h8000 + i * 64 + ns * 16 + pr * 4 + n);
            cz  = CAUSE_W'(i * 3 + ns + pr * 2 + n + 1);
            epc = pr ? apc : gpc;
            start_ch(i, ns[0], gpc);
            chk(st(i) == 1, "R12 start executes", st(i), 1);
            chk(ch_pc[i*PC_W +: PC_W] == gpc, "R6 start pc", ch_pc[i*PC_W +: PC_W], gpc);
            chk(ch_ns_valid[i] && ch_ns[i] == ns[0], "R11 ns while running", ch_ns[i], ns);
            kill(1'b1, 1'b1, i, 8'h01);
            chk(st(i) == 1, "R8 kill while executing ignored", st(i), 1);
            ch_outstanding[i*OST_W +: OST_W] = OST_W'(n);
            abort_ch(i, pr[0], cz, apc);
            chk(st(i) == 2, "R1 enter fault-completing", st(i), 2);
            chk(ch_cache_inv[i] && ch_quiesce[i], "R1 inv and quiesce",
                {ch_cache_inv[i], ch_quiesce[i]}, 2'b11);
            chk(irq_abort == 1, "R4 irq on abort", irq_abort, 1);
            chk(ch_fault[i] == 1, "R5 fault flag draining", ch_fault[i], 1);
            chk(ch_cause[i*CAUSE_W +: CAUSE_W] == cz, "R5 cause", ch_cause[i*CAUSE_W +: CAUSE_W], cz);
            chk(ch_pc[i*PC_W +: PC_W] == epc, "R6 abort pc", ch_pc[i*PC_W +: PC_W], epc);
            for (int k = n; k > 0; k--) begin
              chk(st(i) == 2 && ch_quiesce[i], "R2 draining holds", st(i), 2);
              if (k == 1) begin
                wr_port(1'b1, 1'b1, DW'(1)); // kill again while draining (kill op held)
              end
              chk(st(i) == 2, "R8 kill while draining ignored", st(i), 2);
              ch_outstanding[i*OST_W +: OST_W] = OST_W'(k - 1);
              tick();
            end
            if (n == 0) tick();
            chk(st(i) == 3, "R2 reach faulting", st(i), 3);
            chk(ch_cache_inv[i] == 0 && ch_quiesce[i] == 0, "R1 pulse ended",
                {ch_cache_inv[i], ch_quiesce[i]}, 0);
            kill(1'b1, 1'b1, i, 8'h02);
            chk(st(i) == 3, "R8 non-kill opcode ignored", st(i), 3);
            kill(1'b0, 1'b1, i, 8'h01);
            if (ns == 0) begin
              chk(st(i) == 3, "R9 ns kill of secure ignored", st(i), 3);
              chk(irq_abort == 1, "R4 irq held", irq_abort, 1);
              kill(1'b1, 1'b1, i, 8'h01);
              chk(st(i) == 0, "R9 secure kill", st(i), 0);
            end else begin
              chk(st(i) == 0, "R9 ns kill of ns thread", st(i), 0);
            end
            chk(st(i) == 0, "R7 killed to stopped", st(i), 0);
            chk(irq_abort == 0, "R4 irq cleared", irq_abort, 0);
            chk(ch_ns_valid[i] == 0 && ch_ns[i] == 0, "R11 ns invalid when stopped",
                {ch_ns_valid[i], ch_ns[i]}, 0);
          end

    // two channels faulting; irq stays until both killed; abort ignored while stopped
    abort_ch(3, 1'b1, 4'h7, 16'hFFFF);
    chk(st(3) == 0, "R12 abort in stopped ignored", st(3), 0);
    start_ch(1, 1'b0, 16'h0100);
    start_ch(2, 1'b1, 16'h0200);
    start_ch(1, 1'b1, 16'h0999);
    chk(ch_pc[1*PC_W +: PC_W] == 16'h0100 && ch_ns[1] == 0, "R12 start ignored when running",
        ch_pc[1*PC_W +: PC_W], 16'h0100);
    abort_ch(1, 1'b0, 4'h9, 16'h0);
    abort_ch(2, 1'b0, 4'hB, 16'h0);
    tick();
    chk(ch_fault == 4'b0110, "R5 fault flags", ch_fault, 4'b0110);
    kill(1'b1, 1'b1, 1, 8'h01);
    chk(irq_abort == 1 && ch_fault == 4'b0100, "R4 irq while other faults", irq_abort, 1);
    kill(1'b0, 1'b1, 2, 8'h01);
    chk(irq_abort == 0 && ch_state == 0, "R4 irq after all killed", irq_abort, 0);

    // manager, secure
    kill(1'b1, 1'b0, 0, 8'h01);
    chk(mgr_state == 0, "R8 kill on stopped manager ignored", mgr_state, 0);
    mgr_go = 1; tick(); mgr_go = 0;
    chk(mgr_state == 1, "R12 manager executes", mgr_state, 1);
    mgr_abort = 1; mgr_abort_cause = 4'hD; tick(); mgr_abort = 0;
    chk(mgr_state == 3, "R3 manager faults directly", mgr_state, 3);
    chk(mgr_fault && mgr_cause == 4'hD && irq_abort, "R5 manager fault status", mgr_cause, 4'hD);
    kill(1'b0, 1'b0, 0, 8'h01);
    chk(mgr_state == 3, "R9 ns kill of secure manager ignored", mgr_state, 3);
    kill(1'b1, 1'b0, 0, 8'h01);
    chk(mgr_state == 0 && !irq_abort, "R7 manager killed", mgr_state, 0);

    // manager, non-secure by configuration
    do_reset(1'b1);
    chk(mgr_ns == 1, "R10 capture ns manager", mgr_ns, 1);
    mgr_go = 1; tick(); mgr_go = 0;
    mgr_abort = 1; mgr_abort_cause = 4'h2; tick(); mgr_abort = 0;
    chk(mgr_state == 3, "R3 manager fault", mgr_state, 3);
    kill(1'b0, 1'b0, 0, 8'h01);
    chk(mgr_state == 0, "R9 ns kill of ns manager", mgr_state, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule